// File: doc/BRIEF.md
# Work Tag State Tracker

This block follows the scheduling-tag state of several processing cores in a hardware work scheduler. For each core it stores the current tag type and a 32-bit tag value. It accepts four kinds of request from that core:

- a tag switch to a target type and tag;
- a new-work load;
- a deschedule;
- a null load.

Every request that is taken is acknowledged one cycle later. Every request that breaks the transition rules is flagged with a one-cycle error pulse.

A shared arbiter stops two cores from holding the same atomic tag value. A core that asks for an atomic tag that another core already holds is stalled. It must hold its request until the acknowledge arrives.

Each core's tracker is a four-state machine whose states are the tag types:

| State | Code | Meaning |
|---|---|---|
| `TT_ORDERED` | 0 | ordered |
| `TT_ATOMIC` | 1 | atomic |
| `TT_NULL` | 2 | null |
| `TT_IDLE` | 3 | null-null, no scheduler slot reserved |

The named transitions are:

- **desched**: any state to `TT_IDLE`.
- **null load**: `TT_IDLE` to `TT_NULL`.
- **new work**: `TT_IDLE` to the target type (`TT_ORDERED`, `TT_ATOMIC` or `TT_NULL`).
- **switch**: `TT_ORDERED`, `TT_ATOMIC` or `TT_NULL` to the target type, except null to null.
- **reject**: an illegal request. The state is held, and error and acknowledge are both raised.
- **stall**: an atomic acquisition that is blocked. The state is held and no acknowledge is given.

Top module: `tagtrk_cluster`

## Requirements
- R1: After reset every core reads type 3 (null-null), tag 0, with ack and err low.
- R2: Tag type is a 2-bit code: 0 ordered, 1 atomic, 2 null, 3 null-null. It is used on the request and status ports.
- R3: A new-work request from null-null loads the requested type and tag. Ack is high in the cycle after the edge that takes the request.
- R4: A null load from null-null moves the core to null. A null load from any other state is illegal.
- R5: A switch is illegal when the current state is null-null, when the target is null-null, or when it goes from null to null.
- R6: A legal switch loads the target type and the target tag.
- R7: A deschedule is always legal, moves the core to null-null and clears the tag.
- R8: When several requests arrive together, only one is taken, in this priority order: deschedule, switch, new work, null load.
- R9: No two cores ever hold type atomic with the same tag value.
- R10: An atomic switch or an atomic new work is stalled (ack low, state unchanged) while another core holds that atomic tag. It is taken at the first edge at which the holder no longer shows it, so ack rises in the cycle after the release.
- R11: When several cores ask for the same free atomic tag in the same cycle, the lowest-numbered core wins. Requests for different tags proceed together.
- R12: A new-work request is illegal when the current state is not null-null, or when the target type is null-null.
- R13: An illegal request gives one err pulse together with ack and leaves type and tag unchanged. Ack and err stay high for one cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| req_desched | input | NCORE | deschedule strobe per core |
| req_switch | input | NCORE | tag switch strobe per core |
| sw_type | input | 2*NCORE | switch target type per core |
| sw_tag | input | TAG_W*NCORE | switch target tag per core |
| req_newwork | input | NCORE | new-work strobe per core |
| nw_type | input | 2*NCORE | new-work tag type per core |
| nw_tag | input | TAG_W*NCORE | new-work tag value per core |
| req_nullload | input | NCORE | null load strobe per core |
| cur_type | output | 2*NCORE | current tag type per core |
| cur_tag | output | TAG_W*NCORE | current tag value per core |
| ack | output | NCORE | request taken, one cycle after the edge |
| err | output | NCORE | illegal request pulse |

## Verification
The transition rules are driven from each starting state with every class of request:

- legal and illegal switches, where null to null, to null-null and from null-null must be rejected;
- new work and null load, tried both from idle and from busy states;
- deschedule from a loaded state.

Requests are also applied together on one core. This shows that only the highest-priority request is taken, including cases where the lower-priority request would itself be illegal. The atomic tests use two cores on one tag value: one case held by another core, one case released while the second core waits, and one case with simultaneous requests. A further case uses different tag values, which separates a true conflict from over-eager stalling.

// File: rtl/tagtrk_pkg.sv
package tagtrk_pkg;
    typedef enum logic [1:0] {
        TT_ORDERED = 2'd0,
        TT_ATOMIC  = 2'd1,
        TT_NULL    = 2'd2,
        TT_IDLE    = 2'd3
    } tag_type_e;

    typedef enum logic [2:0] {
        OP_NONE     = 3'd0,
        OP_DESCHED  = 3'd1,
        OP_SWITCH   = 3'd2,
        OP_NEWWORK  = 3'd3,
        OP_NULLLOAD = 3'd4
    } op_e;
endpackage

// File: rtl/tagtrk_req_sel.sv
module tagtrk_req_sel
    import tagtrk_pkg::*;
#(
    parameter int TAG_W = 32
) (
    input  logic             desched,
    input  logic             switch_req,
    input  logic [1:0]       sw_type,
    input  logic [TAG_W-1:0] sw_tag,
    input  logic             newwork,
    input  logic [1:0]       nw_type,
    input  logic [TAG_W-1:0] nw_tag,
    input  logic             nullload,
    output op_e              op,
    output tag_type_e        tgt_type,
    output logic [TAG_W-1:0] tgt_tag
);
    // R8: fixed priority desched > switch > new work > null load
    always_comb begin
        op       = OP_NONE;
        tgt_type = TT_IDLE;
        tgt_tag  = '0;
        if (desched) begin
            op = OP_DESCHED;
        end else if (switch_req) begin
            op       = OP_SWITCH;
            tgt_type = tag_type_e'(sw_type);
            tgt_tag  = sw_tag;
        end else if (newwork) begin
            op       = OP_NEWWORK;
            tgt_type = tag_type_e'(nw_type);
            tgt_tag  = nw_tag;
        end else if (nullload) begin
            op       = OP_NULLLOAD;
            tgt_type = TT_NULL;
        end
    end
endmodule

// File: rtl/tagtrk_core.sv
module tagtrk_core
    import tagtrk_pkg::*;
#(
    parameter int TAG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  op_e              op,
    input  tag_type_e        tgt_type,
    input  logic [TAG_W-1:0] tgt_tag,
    input  logic             grant,
    output logic             want_atomic,
    output logic [TAG_W-1:0] want_tag,
    output tag_type_e        cur_type,
    output logic [TAG_W-1:0] cur_tag,
    output logic             ack,
    output logic             err
);
    tag_type_e        state_q, state_d;
    logic [TAG_W-1:0] tag_q, tag_d;
    logic             illegal, take, nxt_ack, nxt_err;

    // transition rules: R4, R5, R12
    always_comb begin
        illegal = 1'b0;
        unique case (op)
            OP_SWITCH:   illegal = (state_q == TT_IDLE) || (tgt_type == TT_IDLE) ||
                                   (state_q == TT_NULL && tgt_type == TT_NULL);
            OP_NEWWORK:  illegal = (state_q != TT_IDLE) || (tgt_type == TT_IDLE);
            OP_NULLLOAD: illegal = (state_q != TT_IDLE);
            OP_NONE, OP_DESCHED: illegal = 1'b0;
            default:     illegal = 1'b0;
        endcase
    end

    assign want_atomic = (op == OP_SWITCH || op == OP_NEWWORK) &&
                         (tgt_type == TT_ATOMIC) && !illegal;
    assign want_tag    = tgt_tag;

    // next-state logic
    always_comb begin
        state_d = state_q;
        tag_d   = tag_q;
        take    = 1'b0;
        nxt_err = 1'b0;
        unique case (op)
            OP_NONE: ;
            OP_DESCHED: begin
                state_d = TT_IDLE;
                tag_d   = '0;
                take    = 1'b1;
            end
            OP_SWITCH, OP_NEWWORK: begin
                if (illegal) begin
                    take    = 1'b1;
                    nxt_err = 1'b1;
                end else if (!want_atomic || grant) begin
                    state_d = tgt_type;
                    tag_d   = tgt_tag;
                    take    = 1'b1;
                end
            end
            OP_NULLLOAD: begin
                take = 1'b1;
                if (illegal) nxt_err = 1'b1;
                else         state_d = TT_NULL;
            end
            default: ;
        endcase
        nxt_ack = take;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TT_IDLE;
            tag_q   <= '0;
        end else begin
            state_q <= state_d;
            tag_q   <= tag_d;
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack <= 1'b0;
            err <= 1'b0;
        end else begin
            ack <= nxt_ack;
            err <= nxt_err;
        end
    end

    assign cur_type = state_q;
    assign cur_tag  = tag_q;

    assert_err_acked_R13: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> ack);
    assert_err_keeps_state_R13: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (cur_type == $past(cur_type) && cur_tag == $past(cur_tag)));
    assert_desched_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_DESCHED) |=> (cur_type == TT_IDLE && cur_tag == '0));
    assert_stall_no_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (want_atomic && !grant) |=> (!ack && $stable(cur_type)));
endmodule

// File: rtl/tagtrk_atomic_arb.sv
module tagtrk_atomic_arb #(
    parameter int NCORE = 4,
    parameter int TAG_W = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NCORE-1:0]       want,
    input  logic [TAG_W-1:0]       want_tag [NCORE],
    input  logic [NCORE-1:0]       held,
    input  logic [TAG_W-1:0]       held_tag [NCORE],
    output logic [NCORE-1:0]       grant
);
    for (genvar i = 0; i < NCORE; i++) begin : g_req
        always_comb begin
            grant[i] = 1'b1;
            for (int j = 0; j < NCORE; j++) begin
                if (j != i && held[j] && held_tag[j] == want_tag[i])
                    grant[i] = 1'b0;   // R10: another core owns this tag
                if (j < i && want[j] && want_tag[j] == want_tag[i])
                    grant[i] = 1'b0;   // R11: lower index wins
            end
        end
    end

    for (genvar i = 0; i < NCORE; i++) begin : g_chk_i
        for (genvar j = i + 1; j < NCORE; j++) begin : g_chk_j
            assert_one_winner_R11: assert property (@(posedge clk) disable iff (!rst_n)
                (want[i] && want[j] && want_tag[i] == want_tag[j]) |-> !(grant[i] && grant[j]));
        end
    end
endmodule

// File: rtl/tagtrk_cluster.sv
module tagtrk_cluster
    import tagtrk_pkg::*;
#(
    parameter int NCORE = 4,
    parameter int TAG_W = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NCORE-1:0]       req_desched,
    input  logic [NCORE-1:0]       req_switch,
    input  logic [2*NCORE-1:0]     sw_type,
    input  logic [TAG_W*NCORE-1:0] sw_tag,
    input  logic [NCORE-1:0]       req_newwork,
    input  logic [2*NCORE-1:0]     nw_type,
    input  logic [TAG_W*NCORE-1:0] nw_tag,
    input  logic [NCORE-1:0]       req_nullload,
    output logic [2*NCORE-1:0]     cur_type,
    output logic [TAG_W*NCORE-1:0] cur_tag,
    output logic [NCORE-1:0]       ack,
    output logic [NCORE-1:0]       err
);
    logic [NCORE-1:0] want, held, grant;
    logic [TAG_W-1:0] want_tag [NCORE];
    logic [TAG_W-1:0] held_tag [NCORE];

    for (genvar c = 0; c < NCORE; c++) begin : g_core
        op_e              op;
        tag_type_e        tgt_type, st;
        logic [TAG_W-1:0] tgt_tag, tg;

        tagtrk_req_sel #(.TAG_W(TAG_W)) sel_i (
            .desched    (req_desched[c]),
            .switch_req (req_switch[c]),
            .sw_type    (sw_type[2*c +: 2]),
            .sw_tag     (sw_tag[TAG_W*c +: TAG_W]),
            .newwork    (req_newwork[c]),
            .nw_type    (nw_type[2*c +: 2]),
            .nw_tag     (nw_tag[TAG_W*c +: TAG_W]),
            .nullload   (req_nullload[c]),
            .op         (op),
            .tgt_type   (tgt_type),
            .tgt_tag    (tgt_tag)
        );

        tagtrk_core #(.TAG_W(TAG_W)) core_i (
            .clk         (clk),
            .rst_n       (rst_n),
            .op          (op),
            .tgt_type    (tgt_type),
            .tgt_tag     (tgt_tag),
            .grant       (grant[c]),
            .want_atomic (want[c]),
            .want_tag    (want_tag[c]),
            .cur_type    (st),
            .cur_tag     (tg),
            .ack         (ack[c]),
            .err         (err[c])
        );

        assign cur_type[2*c +: 2]         = st;
        assign cur_tag[TAG_W*c +: TAG_W]  = tg;
        assign held[c]                    = (st == TT_ATOMIC);
        assign held_tag[c]                = tg;
    end

    tagtrk_atomic_arb #(.NCORE(NCORE), .TAG_W(TAG_W)) arb_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .want     (want),
        .want_tag (want_tag),
        .held     (held),
        .held_tag (held_tag),
        .grant    (grant)
    );

    for (genvar i = 0; i < NCORE; i++) begin : g_excl_i
        for (genvar j = i + 1; j < NCORE; j++) begin : g_excl_j
            assert_atomic_unique_R9: assert property (@(posedge clk) disable iff (!rst_n)
                !(held[i] && held[j] && held_tag[i] == held_tag[j]));
        end
    end
endmodule

// File: tb/tagtrk_cluster_tb.sv
module tagtrk_cluster_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 4;
    localparam int TW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] rd, rs, rn, rl;
    logic [1:0]    ty_a [N];
    logic [TW-1:0] tg_a [N];
    logic [2*N-1:0]  swt, nwt, cty;
    logic [TW*N-1:0] swg, nwg, ctg;
    logic [N-1:0] ack, err;
    int checks = 0, fails = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always_comb begin
        for (int c = 0; c < N; c++) begin
            swt[2*c +: 2]   = ty_a[c];
            nwt[2*c +: 2]   = ty_a[c];
            swg[TW*c +: TW] = tg_a[c];
            nwg[TW*c +: TW] = tg_a[c];
        end
    end

    tagtrk_cluster #(.NCORE(N), .TAG_W(TW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_desched(rd), .req_switch(rs), .sw_type(swt), .sw_tag(swg),
        .req_newwork(rn), .nw_type(nwt), .nw_tag(nwg), .req_nullload(rl),
        .cur_type(cty), .cur_tag(ctg), .ack(ack), .err(err)
    );

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic core_is(string req, int c, logic [1:0] t, logic [TW-1:0] g,
                           logic a, logic e);
        chk(req, $sformatf("type%0d", c), 64'(cty[2*c +: 2]), 64'(t));
        chk(req, $sformatf("tag%0d", c),  64'(ctg[TW*c +: TW]), 64'(g));
        chk(req, $sformatf("ack%0d", c),  64'(ack[c]), 64'(a));
        chk(req, $sformatf("err%0d", c),  64'(err[c]), 64'(e));
    endtask

    task automatic clr();
        rd = '0; rs = '0; rn = '0; rl = '0;
        for (int c = 0; c < N; c++) begin ty_a[c] = 2'd0; tg_a[c] = '0; end
    endtask

    task automatic req(int c, bit d, bit s, bit n, bit l, logic [1:0] t, logic [TW-1:0] g);
        rd[c] = d; rs[c] = s; rn[c] = n; rl[c] = l; ty_a[c] = t; tg_a[c] = g;
    endtask

    task automatic step();
        @(posedge clk); @(negedge clk);
    endtask

    // one request on one core, then clear
    task automatic one(int c, bit d, bit s, bit n, bit l, logic [1:0] t, logic [TW-1:0] g);
        req(c, d, s, n, l, t, g); step(); clr();
    endtask

    task automatic t_reset();
        for (int c = 0; c < N; c++) core_is("R1", c, 2'd3, '0, 0, 0);
    endtask

    task automatic t_newwork();
        one(0, 0, 0, 1, 0, 2'd0, 32'h11);
        core_is("R3", 0, 2'd0, 32'h11, 1, 0);   // R2 ordered = 0
        step();
        chk("R13", "ack0 single", 64'(ack[0]), 64'd0);
    endtask

    task automatic t_switch();
        one(0, 0, 1, 0, 0, 2'd2, 32'h22);
        core_is("R6", 0, 2'd2, 32'h22, 1, 0);
        one(0, 0, 1, 0, 0, 2'd2, 32'h99);        // null -> null
        core_is("R5", 0, 2'd2, 32'h22, 1, 1);
        step();
        chk("R13", "err0 single", 64'(err[0]), 64'd0);
        one(0, 0, 1, 0, 0, 2'd3, 32'h5);         // to null-null
        core_is("R5", 0, 2'd2, 32'h22, 1, 1);
        one(0, 0, 1, 0, 0, 2'd0, 32'h33);
        core_is("R6", 0, 2'd0, 32'h33, 1, 0);
        one(0, 0, 0, 1, 0, 2'd0, 32'h44);        // new work while busy
        core_is("R12", 0, 2'd0, 32'h33, 1, 1);
        one(0, 0, 0, 0, 1, 2'd0, 32'h0);         // null load while busy
        core_is("R4", 0, 2'd0, 32'h33, 1, 1);
    endtask

    task automatic t_desched();
        one(0, 1, 0, 0, 0, 2'd0, 32'h0);
        core_is("R7", 0, 2'd3, '0, 1, 0);
        one(0, 0, 1, 0, 0, 2'd0, 32'h7);         // switch from null-null
        core_is("R5", 0, 2'd3, '0, 1, 1);
        one(0, 0, 0, 1, 0, 2'd3, 32'h7);         // new work to null-null
        core_is("R12", 0, 2'd3, '0, 1, 1);
        one(0, 0, 0, 0, 1, 2'd0, 32'h0);
        core_is("R4", 0, 2'd2, '0, 1, 0);
        one(0, 1, 0, 0, 0, 2'd0, 32'h0);
        core_is("R7", 0, 2'd3, '0, 1, 0);
    endtask

    task automatic t_priority();
        one(1, 0, 0, 1, 1, 2'd0, 32'hA1);        // new work beats null load
        core_is("R8", 1, 2'd0, 32'hA1, 1, 0);
        one(1, 0, 1, 1, 0, 2'd2, 32'hA2);        // switch beats new work
        core_is("R8", 1, 2'd2, 32'hA2, 1, 0);
        one(1, 1, 1, 1, 1, 2'd0, 32'hA3);        // desched beats all
        core_is("R8", 1, 2'd3, '0, 1, 0);
    endtask

    task automatic t_atomic_stall();
        one(0, 0, 0, 1, 0, 2'd1, 32'hAB);
        core_is("R3", 0, 2'd1, 32'hAB, 1, 0);   // R2 atomic = 1
        req(1, 0, 0, 1, 0, 2'd1, 32'hAB); step();
        core_is("R10", 1, 2'd3, '0, 0, 0);
        step();
        core_is("R10", 1, 2'd3, '0, 0, 0);
        req(0, 1, 0, 0, 0, 2'd0, 32'h0); step();
        rd[0] = 1'b0;
        core_is("R7", 0, 2'd3, '0, 1, 0);
        core_is("R10", 1, 2'd3, '0, 0, 0);       // released at this edge
        step();
        core_is("R10", 1, 2'd1, 32'hAB, 1, 0);
        clr();
        one(0, 0, 0, 1, 0, 2'd0, 32'hAB);        // ordered on same value is fine
        core_is("R9", 0, 2'd0, 32'hAB, 1, 0);
        req(0, 0, 1, 0, 0, 2'd1, 32'hAB); step(); // switch to atomic stalls
        core_is("R10", 0, 2'd0, 32'hAB, 0, 0);
        req(1, 1, 0, 0, 0, 2'd0, 32'h0); step();
        rd[1] = 1'b0; step();
        core_is("R10", 0, 2'd1, 32'hAB, 1, 0);
        clr();
        one(0, 1, 0, 0, 0, 2'd0, 32'h0);
    endtask

    task automatic t_simul();
        req(2, 0, 0, 1, 0, 2'd1, 32'h55);
        req(3, 0, 0, 1, 0, 2'd1, 32'h55); step();
        core_is("R11", 2, 2'd1, 32'h55, 1, 0);
        core_is("R11", 3, 2'd3, '0, 0, 0);
        clr();
        one(2, 1, 0, 0, 0, 2'd0, 32'h0);
        req(2, 0, 0, 1, 0, 2'd1, 32'h61);
        req(3, 0, 0, 1, 0, 2'd1, 32'h62); step();
        core_is("R11", 2, 2'd1, 32'h61, 1, 0);
        core_is("R11", 3, 2'd1, 32'h62, 1, 0);
        clr();
    endtask

    initial begin
        clr();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_newwork();
        t_switch();
        t_desched();
        t_priority();
        t_atomic_stall();
        t_simul();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule